// File: doc/BRIEF.md
# Serial-Loaded Register Write Port

This block sits on a CPU bus and takes writes aimed at the upper half of the address space. Software cannot load its registers in a single bus write. Instead, a value is built one bit per write in a hidden shift register, starting with the least significant bit. On the fifth accepted data bit, the assembled 5-bit value is committed to one of four internal registers: a control register, two pattern-bank registers and a program-bank register. The address of that fifth write alone picks the target.

A write with data bit 7 set acts as a restart. It abandons the partial value and forces the two program-layout bits of the control register high. A spacing guard counts CPU cycles, not system clocks. It drops any write that lands on the CPU cycle directly after an accepted one, so a read-modify-write pair only acts through its first write. The four register values are driven out continuously for the bank-translation logic downstream.

Top module: `serial_cfg_port`

## Requirements
- R1: A write takes part only when `cpu_en_i` and `wr_i` are high and `addr_i[2]` (address bit 15) is 1. Of `data_i`, only bit 7 (restart flag) and bit 0 (serial bit) have any effect. A write with `addr_i[2]`=0 changes nothing.
- R2: Serial bits are taken least significant first. Five accepted writes with bit 7 clear form one 5-bit value, and the first bit lands in bit 0 of that value.
- R3: Only the address of the fifth write chooses the target. With `addr_i[1:0]` = 0 the target is control, 1 is pattern bank 0, 2 is pattern bank 1 and 3 is program bank. The addresses of the first four writes are ignored, and no other register changes.
- R4: Once a value is committed, the next accepted data write counts as the first bit of a new value.
- R5: An accepted write with bit 7 set ignores bit 0 and empties the partial value. It sets control bits 2 and 3 to 1 and leaves every other register bit as it was.
- R6: After reset, control reads 5'h0C and the other three registers read 0. This includes the program-bank work-RAM-disable bit 4, so work RAM starts enabled.
- R7: A write on the CPU cycle directly after an accepted write is ignored. A write two or more CPU cycles later is accepted. Restart writes arm this guard too.
- R8: A write rejected by the spacing guard changes neither the partial value nor any register.
- R9: Nothing changes in a system clock where `cpu_en_i` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_en_i | input | 1 | One-clock pulse marking a CPU cycle |
| wr_i | input | 1 | CPU write strobe, qualified by `cpu_en_i` |
| addr_i | input | 3 | CPU address bits 15:13 |
| data_i | input | 8 | CPU write data |
| ctrl_o | output | 5 | Control register |
| bank0_o | output | 5 | Pattern bank 0 register |
| bank1_o | output | 5 | Pattern bank 1 register |
| prog_o | output | 5 | Program bank register (bit 4 = work-RAM disable) |

## Verification
The assertions assume that `wr_i`, `addr_i` and `data_i` are only meaningful in a clock where `cpu_en_i` pulses. They also assume that a CPU cycle lasts one system clock at the enable. The bench keeps to this by driving every input on the falling edge, holding it for exactly one rising edge and then dropping `cpu_en_i` and `wr_i`. Random stimulus also offers writes with `cpu_en_i` low, which the design must ignore. Back-to-back enabled writes are produced on purpose, both directed and random, so the guard is exercised at its boundary.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int unsigned VAL_W_DEF  = 5;
  localparam int unsigned DATA_W_DEF = 8;

  typedef enum logic [1:0] {
    TGT_CTRL  = 2'd0,
    TGT_BANK0 = 2'd1,
    TGT_BANK1 = 2'd2,
    TGT_PROG  = 2'd3
  } target_e;
endpackage

// File: rtl/spacing_guard.sv
module spacing_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_en_i,
  input  logic req_i,
  output logic accept_o,
  output logic blocked_o
);
  logic armed_q;

  assign accept_o  = cpu_en_i & req_i & ~armed_q;
  assign blocked_o = cpu_en_i & req_i & armed_q;

  // armed only for the CPU cycle right after an accepted write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (cpu_en_i) armed_q <= accept_o;
  end

  a_r7_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
endmodule

// File: rtl/shift_assembler.sv
module shift_assembler #(
  parameter int unsigned VAL_W = 5,
  localparam int unsigned CNT_W = $clog2(VAL_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             clear_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic [VAL_W-1:0] value_o,
  output logic [CNT_W-1:0] count_o
);
  logic [VAL_W-2:0] sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last    = (cnt_q == CNT_W'(VAL_W - 1));
  assign done_o  = take_i & ~clear_i & last;
  assign value_o = {bit_i, sr_q};
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i || done_o) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      sr_q  <= {bit_i, sr_q[VAL_W-2:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r2_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(VAL_W));
  a_r4_restart_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_q == '0);
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int unsigned VAL_W = 5,
  parameter int unsigned SEL_W = 2,
  parameter logic [VAL_W-1:0] CTRL_RST   = 5'h0C,
  parameter logic [VAL_W-1:0] FORCE_MASK = 5'h0C,
  localparam int unsigned NREG = 1 << SEL_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [VAL_W-1:0]           value_i,
  input  logic                       force_i,
  output logic [NREG-1:0][VAL_W-1:0] regs_o
);
  logic [NREG-1:0] we;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [VAL_W-1:0] RST_V = (g == 0) ? CTRL_RST : '0;
    logic [VAL_W-1:0] q;

    assign we[g] = commit_i && (sel_i == SEL_W'(g));

    if (g == 0) begin : g_ctrl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= RST_V;
        else if (we[g])   q <= value_i;
        else if (force_i) q <= q | FORCE_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q <= RST_V;
        else if (we[g]) q <= value_i;
      end
    end

    assign regs_o[g] = q;
  end

  a_r3_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
  a_r5_no_commit_with_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(force_i && commit_i));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
#(
  parameter int unsigned VAL_W   = VAL_W_DEF,
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned RST_BIT = 7,
  parameter logic [VAL_W-1:0] CTRL_RST   = 5'h0C,
  parameter logic [VAL_W-1:0] FORCE_MASK = 5'h0C,
  localparam int unsigned SEL_W = ADDR_W - 1,
  localparam int unsigned NREG  = 1 << SEL_W,
  localparam int unsigned CNT_W = $clog2(VAL_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [VAL_W-1:0]  ctrl_o,
  output logic [VAL_W-1:0]  bank0_o,
  output logic [VAL_W-1:0]  bank1_o,
  output logic [VAL_W-1:0]  prog_o
);
  logic req, accept, blocked, restart, take, done;
  logic [VAL_W-1:0] value;
  logic [CNT_W-1:0] count;
  logic [NREG-1:0][VAL_W-1:0] regs;

  assign req     = wr_i & addr_i[ADDR_W-1];
  assign restart = data_i[RST_BIT];
  assign take    = accept & ~restart;

  spacing_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cpu_en_i (cpu_en_i),
    .req_i    (req),
    .accept_o (accept),
    .blocked_o(blocked)
  );

  shift_assembler #(.VAL_W(VAL_W)) u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .clear_i(accept & restart),
    .bit_i  (data_i[0]),
    .done_o (done),
    .value_o(value),
    .count_o(count)
  );

  reg_bank #(
    .VAL_W     (VAL_W),
    .SEL_W     (SEL_W),
    .CTRL_RST  (CTRL_RST),
    .FORCE_MASK(FORCE_MASK)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(done),
    .sel_i   (addr_i[SEL_W-1:0]),
    .value_i (value),
    .force_i (accept & restart),
    .regs_o  (regs)
  );

  assign ctrl_o  = regs[TGT_CTRL];
  assign bank0_o = regs[TGT_BANK0];
  assign bank1_o = regs[TGT_BANK1];
  assign prog_o  = regs[TGT_PROG];

  a_r1_low_half_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en_i && wr_i && !addr_i[ADDR_W-1]) |=> ($stable(count) && $stable(regs)));
  a_r8_blocked_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> ($stable(count) && $stable(regs)));
  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_en_i |=> ($stable(count) && $stable(regs)));
  a_r5_restart_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && restart) |=> ((ctrl_o & FORCE_MASK) == FORCE_MASK && count == '0));
endmodule

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_en = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic [4:0] ctrl, bank0, bank1, prog;

  int n_chk = 0, n_fail = 0;
  logic [4:0] m_reg [4];
  logic [4:0] m_sr;
  int m_cnt;
  logic m_armed;

  always #2 clk = ~clk;

  serial_cfg_port u_serial_cfg_port (
    .clk_i(clk), .rst_ni(rst_n), .cpu_en_i(cpu_en), .wr_i(wr),
    .addr_i(addr), .data_i(data),
    .ctrl_o(ctrl), .bank0_o(bank0), .bank1_o(bank1), .prog_o(prog)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " ctrl"},  ctrl,  m_reg[0]);
    chk({tag, " bank0"}, bank0, m_reg[1]);
    chk({tag, " bank1"}, bank1, m_reg[2]);
    chk({tag, " prog"},  prog,  m_reg[3]);
  endtask

  // one system clock with the given inputs; model follows the requirements
  task automatic cyc(input logic en, input logic w, input logic [2:0] a, input logic [7:0] d);
    logic acc;
    cpu_en = en; wr = w; addr = a; data = d;
    @(negedge clk);
    cpu_en = 1'b0; wr = 1'b0;
    if (en) begin
      acc = w && a[2] && !m_armed;
      m_armed = acc;
      if (acc) begin
        if (d[7]) begin
          m_cnt = 0; m_sr = '0; m_reg[0] = m_reg[0] | 5'h0C;
        end else if (m_cnt == 4) begin
          m_sr[4] = d[0];
          m_reg[a[1:0]] = m_sr;
          m_cnt = 0; m_sr = '0;
        end else begin
          m_sr[m_cnt] = d[0];
          m_cnt++;
        end
      end
    end
  endtask

  // a CPU cycle without a write, keeps the guard apart
  task automatic gap();
    cyc(1'b1, 1'b0, 3'b100, 8'h00);
  endtask

  task automatic load(input logic [2:0] first_a, input logic [2:0] last_a, input logic [4:0] v);
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 1'b1, (i == 4) ? last_a : first_a, {7'b0, v[i]});
      gap();
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_reg[0] = 5'h0C; m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
    m_sr = '0; m_cnt = 0; m_armed = 1'b0;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    chk("R6 ctrl", ctrl, 5'h0C);
    chk("R6 bank0", bank0, 5'h00);
    chk("R6 bank1", bank1, 5'h00);
    chk("R6 prog wram", prog, 5'h00);

    // R2 R3: four bits at 0x8000, fifth at 0xE000
    load(3'b100, 3'b111, 5'h16);
    chk("R3 prog target", prog, 5'h16);
    chk("R3 ctrl untouched", ctrl, 5'h0C);
    chk("R3 bank0 untouched", bank0, 5'h00);

    // R4 next value starts fresh
    load(3'b111, 3'b101, 5'h09);
    chk("R4 bank0", bank0, 5'h09);

    // R5 restart after two bits restarts the count
    cyc(1, 1, 3'b100, 8'h01); gap();
    cyc(1, 1, 3'b100, 8'h01); gap();
    cyc(1, 1, 3'b100, 8'h80); gap();
    load(3'b100, 3'b110, 5'h05);
    chk("R5 bank1 after restart", bank1, 5'h05);

    // R5 restart forces ctrl bits 3:2 only
    load(3'b100, 3'b100, 5'h13);
    chk("R3 ctrl write", ctrl, 5'h13);
    cyc(1, 1, 3'b101, 8'hFF); gap();
    chk("R5 ctrl forced", ctrl, 5'h1F);
    chk("R5 bank0 kept", bank0, 5'h09);

    // R7 read-modify-write pair: only 0xFF counts
    cyc(1, 1, 3'b111, 8'hFF);
    cyc(1, 1, 3'b111, 8'h00);
    gap();
    load(3'b100, 3'b101, 5'h1A);
    chk("R7 back-to-back dropped", bank0, 5'h1A);

    // R8 blocked restart mid-sequence changes nothing; R1 and R9 ignored writes
    cyc(1, 1, 3'b100, 8'h01);
    cyc(1, 1, 3'b100, 8'h80);            // R8 blocked
    gap();
    cyc(1, 1, 3'b011, 8'h81); gap();     // R1 low half
    cyc(0, 1, 3'b100, 8'h80); gap();     // R9 no enable
    cyc(1, 1, 3'b100, 8'h7E); gap();     // R1 bits 6:1 ignored, bit0=0
    cyc(1, 1, 3'b100, 8'h01); gap();
    cyc(1, 1, 3'b100, 8'h00); gap();
    cyc(1, 1, 3'b110, 8'h01); gap();
    chk("R8 R1 R9 bank1", bank1, 5'b10101);
    chk("R8 ctrl kept", ctrl, 5'h1F);

    // random mix checked against the model (R1..R9)
    for (int i = 0; i < 600; i++) begin
      logic [2:0] ra;
      logic [7:0] rd;
      logic en, w;
      en = ($urandom_range(0, 7) != 0);
      w  = ($urandom_range(0, 2) != 0);
      ra = 3'($urandom);
      rd = 8'($urandom);
      if ($urandom_range(0, 9) != 0) rd[7] = 1'b0;
      cyc(en, w, ra, rd);
      if (i % 10 == 9) chk_model("R2 R3 R7 random");
    end
    chk_model("R5 R8 final");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule